// File: doc/BRIEF.md
# Piecewise-Linear Numerically Controlled Oscillator

This block turns a signed digital control word into a square wave. The relation between control and frequency is a curve set at build time as a list of breakpoints. Each breakpoint pairs a control value with a frequency in hertz. Between two neighbouring breakpoints the frequency is interpolated on a straight line. Below the first breakpoint or above the last one, the first or last segment is extended. Each result is turned into a phase increment for a 32-bit accumulator that runs on the system clock. If no curve is given, every breakpoint sits at 1 MHz, so the frequency is flat.

The accumulator starts from a preset that the build-time initial phase sets, in degrees from -180 to +360. The wave is high while the accumulator is below a duty threshold that can be changed at run time. Rising and falling output edges each have their own delay, counted in clock cycles. A level must hold longer than its delay before it reaches the output, so a shorter pulse never appears. Segment slopes are fixed-point constants worked out at elaboration, so the block needs no divider at run time.

Top module: `pwl_nco`

## Requirements
- R1: While rst_n is low, phase_inc and osc_out are 0. The internal reset is released on the second rising clock edge after rst_n rises. phase_inc first follows ctl_word on the third edge.
- R2: Each breakpoint frequency F becomes the tuning word T = floor(F·2^32 / CLK_HZ). phase_inc is registered and reflects ctl_word one clock edge later.
- R3: When ctl_word equals any breakpoint except the last, phase_inc equals that breakpoint's T exactly.
- R4: Segment k is the highest k in 0..N-2 with ctl_word ≥ C[k], or k = 0 below C[1]. Its slope is S[k] = trunc((T[k+1]−T[k])·2^16 / (C[k+1]−C[k])). The result is phase_inc = T[k] + floor(S[k]·(ctl_word − C[k]) / 2^16).
- R5: Control values below the first breakpoint or above the last one use the formula of R4 on the first or last segment.
- R6: A negative result of R4 gives phase_inc = 0. The accumulator then holds its value and osc_out does not change.
- R7: A result above 2^32−1 gives phase_inc = 0xFFFFFFFF.
- R8: On every edge the accumulator adds phase_inc. The raw wave is high when the accumulator is below duty_frac, so the share of time spent high is duty_frac / 2^32.
- R9: On reset the accumulator is loaded with floor(d·2^32/360). Here d is INIT_DEG brought into 0..359 by adding 360 to a negative value, or by subtracting 360 from 360.
- R10: A rising raw-wave level reaches osc_out only after it has held for rise_dly+1 edges. A high pulse shorter than that is dropped.
- R11: A falling raw-wave level reaches osc_out only after it has held for fall_dly+1 edges. This is independent of rise_dly, and a shorter low pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_word | input | CW (16) | Signed control value |
| duty_frac | input | ACC_W (32) | High threshold, as a fraction of 2^32 |
| rise_dly | input | DLY_W (8) | Rising-edge delay in cycles |
| fall_dly | input | DLY_W (8) | Falling-edge delay in cycles |
| phase_inc | output | ACC_W (32) | Current accumulator increment |
| osc_out | output | 1 | Delayed square-wave output |

## Verification
The hardest cases to reach from the ports are the clamped ends of the curve. One is an extrapolated increment below zero, which freezes the accumulator. The other is an increment past 2^32, which saturates. The bench uses a curve whose lowest segment rises steeply, then drives control values far outside the breakpoints. Dropped pulses are also difficult to reach. To produce raw pulses of one or two cycles, the bench runs a 20 MHz tone against a quarter or three-quarter duty. It then sets the matching edge delay longer than those pulses.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // Tuning word of a frequency: floor(hz * 2^acc_w / clk_hz)
  function automatic longint hz_to_tw(longint hz, longint clk_hz, int acc_w);
    return (hz <<< acc_w) / clk_hz;
  endfunction

  // Fixed-point slope of a segment, truncated toward zero
  function automatic longint seg_slope(longint tw_lo, longint tw_hi,
                                       longint c_lo, longint c_hi, int sf);
    return ((tw_hi - tw_lo) <<< sf) / (c_hi - c_lo);
  endfunction

  // Accumulator preset for a start phase in degrees (-180..360)
  function automatic longint deg_to_phase(int deg, int acc_w);
    longint d;
    d = longint'(deg);
    if (d < 0) d = d + 360;
    else if (d >= 360) d = d - 360;
    return (d <<< acc_w) / 360;
  endfunction

endpackage

// File: rtl/nco_pwl_map.sv
module nco_pwl_map #(
  parameter int                  NPTS    = 4,
  parameter int                  CW      = 16,
  parameter int                  ACC_W   = 32,
  parameter int                  SF      = 16,
  parameter longint              CLK_HZ  = 125_000_000,
  parameter logic [NPTS*CW-1:0]  CTL_PTS = '0,
  parameter logic [NPTS*32-1:0]  FREQ_HZ = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [CW-1:0] ctl_i,
  output logic [ACC_W-1:0]     inc_o
);
  localparam int SEG_W = (NPTS > 2) ? $clog2(NPTS - 1) : 1;
  localparam int SW    = ACC_W + SF + 2;
  localparam int DW    = CW + 1;
  localparam int PW    = SW + DW;

  logic signed [CW-1:0]  pt_ctl    [NPTS];
  logic [ACC_W-1:0]      pt_tw     [NPTS];
  logic signed [SW-1:0]  seg_slope [NPTS-1];

  for (genvar g = 0; g < NPTS; g++) begin : g_pt
    localparam longint TWV =
      nco_pkg::hz_to_tw(longint'(FREQ_HZ[g*32 +: 32]), CLK_HZ, ACC_W);
    assign pt_ctl[g] = CTL_PTS[g*CW +: CW];
    assign pt_tw[g]  = TWV[ACC_W-1:0];
  end

  for (genvar s = 0; s < NPTS - 1; s++) begin : g_seg
    localparam longint SLV = nco_pkg::seg_slope(
      nco_pkg::hz_to_tw(longint'(FREQ_HZ[s*32 +: 32]), CLK_HZ, ACC_W),
      nco_pkg::hz_to_tw(longint'(FREQ_HZ[(s+1)*32 +: 32]), CLK_HZ, ACC_W),
      longint'($signed(CTL_PTS[s*CW +: CW])),
      longint'($signed(CTL_PTS[(s+1)*CW +: CW])), SF);
    assign seg_slope[s] = SLV[SW-1:0];
  end

  logic [SEG_W-1:0]      seg;
  logic signed [DW-1:0]  delta;
  logic signed [PW-1:0]  prod, shifted, base_ext, sum;
  logic [ACC_W-1:0]      inc_d, inc_q;

  always_comb begin
    seg = '0;
    for (int i = 1; i < NPTS - 1; i++)
      if (ctl_i >= pt_ctl[i]) seg = SEG_W'(i);
    delta    = {ctl_i[CW-1], ctl_i} - {pt_ctl[seg][CW-1], pt_ctl[seg]};
    prod     = seg_slope[seg] * delta;
    shifted  = prod >>> SF;
    base_ext = {{(PW-ACC_W){1'b0}}, pt_tw[seg]};
    sum      = base_ext + shifted;
    if (sum[PW-1])                inc_d = '0;
    else if (|sum[PW-2:ACC_W])    inc_d = '1;
    else                          inc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inc_q <= '0;
    else        inc_q <= inc_d;
  end

  assign inc_o = inc_q;

  for (genvar s = 0; s < NPTS - 1; s++) begin : g_chk
    // R3: a breakpoint control value lands exactly on its tuning word
    a_r3_breakpoint_exact: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_i == pt_ctl[s]) |=> (inc_q == pt_tw[s]));
  end

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W    = 32,
  parameter int INIT_DEG = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] inc_i,
  input  logic [ACC_W-1:0] duty_i,
  output logic             wave_o
);
  localparam longint PRESET_L = nco_pkg::deg_to_phase(INIT_DEG, ACC_W);
  localparam logic [ACC_W-1:0] PRESET = PRESET_L[ACC_W-1:0];

  logic [ACC_W-1:0] acc_d, acc_q;
  logic             wave_d, wave_q;

  always_comb begin
    acc_d  = acc_q + inc_i;
    wave_d = (acc_q < duty_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= PRESET;
      wave_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      wave_q <= wave_d;
    end
  end

  assign wave_o = wave_q;

  // R6: a zero increment freezes the phase
  a_r6_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i == '0) |=> (acc_q == $past(acc_q)));

endmodule

// File: rtl/nco_edge_delay.sv
module nco_edge_delay #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wave_i,
  input  logic [DLY_W-1:0] rise_i,
  input  logic [DLY_W-1:0] fall_i,
  output logic             out_o
);
  logic             out_d, out_q;
  logic [DLY_W-1:0] cnt_d, cnt_q, tgt;

  always_comb begin
    tgt   = wave_i ? rise_i : fall_i;
    out_d = out_q;
    cnt_d = '0;
    if (wave_i != out_q) begin
      if (cnt_q >= tgt) out_d = wave_i;
      else              cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      out_q <= out_d;
      cnt_q <= cnt_d;
    end
  end

  assign out_o = out_q;

  // R10: output only ever moves toward the raw level
  a_r10_moves_to_wave: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> (out_q == $past(wave_i)));
  a_r10_hold_when_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_i == out_q) |=> $stable(out_q));
  // R10: no rise before the rise delay has run out
  a_r10_rise_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_i && !out_q && (cnt_q < rise_i)) |=> !out_q);
  // R11: no fall before the fall delay has run out
  a_r11_fall_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (!wave_i && out_q && (cnt_q < fall_i)) |=> out_q);

endmodule

// File: rtl/pwl_nco.sv
module pwl_nco #(
  parameter int                  NPTS     = 4,
  parameter int                  CW       = 16,
  parameter int                  ACC_W    = 32,
  parameter int                  SF       = 16,
  parameter int                  DLY_W    = 8,
  parameter int                  INIT_DEG = 0,
  parameter longint              CLK_HZ   = 125_000_000,
  parameter logic [NPTS*CW-1:0]  CTL_PTS  = {16'd2000, 16'd1000, 16'hFC18, 16'hF830},
  parameter logic [NPTS*32-1:0]  FREQ_HZ  = {NPTS{32'd1_000_000}}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [CW-1:0] ctl_word,
  input  logic [ACC_W-1:0]     duty_frac,
  input  logic [DLY_W-1:0]     rise_dly,
  input  logic [DLY_W-1:0]     fall_dly,
  output logic [ACC_W-1:0]     phase_inc,
  output logic                 osc_out
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       wave;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  nco_pwl_map #(
    .NPTS(NPTS), .CW(CW), .ACC_W(ACC_W), .SF(SF), .CLK_HZ(CLK_HZ),
    .CTL_PTS(CTL_PTS), .FREQ_HZ(FREQ_HZ)
  ) u_map (
    .clk(clk), .rst_n(rst_int_n), .ctl_i(ctl_word), .inc_o(phase_inc)
  );

  nco_phase_acc #(.ACC_W(ACC_W), .INIT_DEG(INIT_DEG)) u_acc (
    .clk(clk), .rst_n(rst_int_n), .inc_i(phase_inc), .duty_i(duty_frac),
    .wave_o(wave)
  );

  nco_edge_delay #(.DLY_W(DLY_W)) u_dly (
    .clk(clk), .rst_n(rst_int_n), .wave_i(wave), .rise_i(rise_dly),
    .fall_i(fall_dly), .out_o(osc_out)
  );

endmodule

// File: tb/tb_pwl_nco.sv
`timescale 1ns/1ps
module tb_pwl_nco;
  localparam int     NP = 4;
  localparam int     CP [NP] = '{-100, 0, 50, 200};
  localparam longint FQ [NP] = '{1_000_000, 5_000_000, 5_000_000, 20_000_000};
  localparam longint CLKHZ   = 125_000_000;
  localparam logic [31:0] PRESET = 32'h8000_0000; // 180 degrees

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic signed [15:0] ctl_word = '0;
  logic [31:0] duty_frac = 32'h8000_0000;
  logic [7:0]  rise_dly = '0, fall_dly = '0;
  logic [31:0] phase_inc;
  logic        osc_out;

  int n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit cmp_en = 1'b0;

  always #4 clk = ~clk;

  pwl_nco #(
    .INIT_DEG(180),
    .CTL_PTS({16'd200, 16'd50, 16'd0, 16'hFF9C}),
    .FREQ_HZ({32'd20_000_000, 32'd5_000_000, 32'd5_000_000, 32'd1_000_000})
  ) dut (
    .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word), .duty_frac(duty_frac),
    .rise_dly(rise_dly), .fall_dly(fall_dly), .phase_inc(phase_inc),
    .osc_out(osc_out)
  );

  function automatic longint tw(longint hz);
    return (hz <<< 32) / CLKHZ;
  endfunction

  function automatic logic [31:0] ref_inc(input int ctl);
    int k;
    longint t0, t1, c0, sl;
    logic signed [95:0] p, s;
    k = 0;
    for (int i = 1; i < NP - 1; i++) if (ctl >= CP[i]) k = i;
    t0 = tw(FQ[k]); t1 = tw(FQ[k+1]); c0 = longint'(CP[k]);
    sl = ((t1 - t0) <<< 16) / (longint'(CP[k+1]) - c0);
    p = sl * (longint'(ctl) - c0);
    s = t0 + (p >>> 16);
    if (s < 0) return 32'h0;
    if (s > 96'sh0FFFF_FFFF) return 32'hFFFF_FFFF;
    return s[31:0];
  endfunction

  // Cycle model of the requirements
  logic [1:0]  m_sync;
  logic [31:0] m_inc, m_acc;
  logic        m_wave, m_out;
  logic [7:0]  m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync <= 2'b00; m_inc <= '0; m_acc <= PRESET;
      m_wave <= 1'b0; m_out <= 1'b0; m_cnt <= '0;
    end else begin
      m_sync <= {m_sync[0], 1'b1};
      if (m_sync[1]) begin
        m_inc  <= ref_inc(int'(ctl_word));
        m_acc  <= m_acc + m_inc;
        m_wave <= (m_acc < duty_frac);
        if (m_wave != m_out) begin
          if (m_cnt >= (m_wave ? rise_dly : fall_dly)) begin
            m_out <= m_wave; m_cnt <= '0;
          end else m_cnt <= m_cnt + 8'd1;
        end else m_cnt <= '0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_en) begin
    chk(cur_req, phase_inc, m_inc);
    chk(cur_req, {31'd0, osc_out}, {31'd0, m_out});
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    cyc(3);
    chk("R1", phase_inc, 32'h0);
    chk("R1", {31'd0, osc_out}, 32'd0);
    cmp_en = 1'b1;
    rst_n = 1'b1;
    cyc(1); chk("R1", phase_inc, 32'h0);
    cyc(1); chk("R1", phase_inc, 32'h0);
    cyc(1); chk("R2", phase_inc, 32'(tw(FQ[1])));
    // R9: 180 degree start with half duty keeps the output low at first
    cur_req = "R9";
    for (int i = 0; i < 8; i++) begin
      chk("R9", {31'd0, osc_out}, 32'd0);
      cyc(1);
    end
    cyc(40);
  endtask

  task automatic t_breakpoints;
    cur_req = "R3";
    for (int i = 0; i < NP - 1; i++) begin
      ctl_word = 16'(CP[i]);
      cyc(2);
      chk("R3", phase_inc, 32'(tw(FQ[i])));
    end
  endtask

  task automatic t_interp;
    int v [4] = '{-50, 25, 120, 199};
    cur_req = "R4";
    foreach (v[i]) begin
      ctl_word = 16'(v[i]);
      cyc(2);
      chk("R4", phase_inc, ref_inc(v[i]));
    end
    cyc(30);
  endtask

  task automatic t_extrap;
    int v [3] = '{-110, 300, 1000};
    cur_req = "R5";
    foreach (v[i]) begin
      ctl_word = 16'(v[i]);
      cyc(2);
      chk("R5", phase_inc, ref_inc(v[i]));
    end
    cyc(30);
  endtask

  task automatic t_clamp;
    logic first;
    int changes;
    cur_req = "R6";
    ctl_word = -16'sd200;
    cyc(2);
    chk("R6", phase_inc, 32'h0);
    cyc(10);
    first = osc_out; changes = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(1);
      if (osc_out != first) changes++;
    end
    chk("R6", 32'(changes), 32'd0);
  endtask

  task automatic t_saturate;
    cur_req = "R7";
    ctl_word = 16'sd32767;
    cyc(2);
    chk("R7", phase_inc, 32'hFFFF_FFFF);
    cyc(10);
  endtask

  task automatic t_duty;
    int highs;
    cur_req = "R8";
    ctl_word = 16'sd200;
    duty_frac = 32'h4000_0000;
    cyc(10);
    highs = 0;
    for (int i = 0; i < 1000; i++) begin cyc(1); highs += int'(osc_out); end
    chk("R8", 32'(highs >= 240 && highs <= 260), 32'd1);
    duty_frac = 32'hC000_0000;
    cyc(10);
    highs = 0;
    for (int i = 0; i < 1000; i++) begin cyc(1); highs += int'(osc_out); end
    chk("R8", 32'(highs >= 740 && highs <= 760), 32'd1);
  endtask

  task automatic t_delays;
    int cnt;
    cur_req = "R10";
    ctl_word = 16'sd0; duty_frac = 32'h8000_0000;
    rise_dly = 8'd3; fall_dly = 8'd1;
    cyc(100);
    cur_req = "R11";
    rise_dly = 8'd1; fall_dly = 8'd4;
    cyc(100);
    // R10: one- and two-cycle high pulses are dropped
    cur_req = "R10";
    ctl_word = 16'sd200; duty_frac = 32'h4000_0000;
    rise_dly = 8'd10; fall_dly = 8'd0;
    cyc(20);
    cnt = 0;
    for (int i = 0; i < 200; i++) begin cyc(1); cnt += int'(osc_out); end
    chk("R10", 32'(cnt), 32'd0);
    // R11: short low pulses are dropped
    cur_req = "R11";
    duty_frac = 32'hC000_0000;
    rise_dly = 8'd0; fall_dly = 8'd10;
    cyc(20);
    cnt = 0;
    for (int i = 0; i < 200; i++) begin cyc(1); cnt += int'(!osc_out); end
    chk("R11", 32'(cnt), 32'd0);
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    t_reset();
    t_breakpoints();
    t_interp();
    t_extrap();
    t_clamp();
    t_saturate();
    t_duty();
    t_delays();
    cmp_en = 1'b0;
    finish_up();
  end

endmodule